// File: doc/BRIEF.md
# Nibble-Wide Ethernet Transmit Framer

This block sits between a MAC transmit path that delivers frames as a byte stream and a 100/10 Mb/s PHY that takes four data bits per transmit clock. The stream carries the frame body only: destination address, source address, type/length field and payload. The block wraps that body into a complete wire frame. It sends a run of preamble bytes and a start delimiter first. Short bodies are zero-filled up to the Ethernet minimum. A 32-bit cyclic check value follows the body. The whole frame goes out as nibbles, one per clock, with a frame-enable and an error flag.

The upstream source offers bytes with a valid/last pair and the framer pulls them with a ready strobe, at most one byte every two clocks. If the source fails to supply a byte when the framer asks for one, the framer does not stall the wire. It sends a zero filler byte and raises the error line until the frame ends, so the PHY can corrupt the frame on the medium. Between frames the framer holds the enable low for at least the inter-frame gap.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is asserted, and in the first clock after it, `tx_en`, `tx_er` and `s_ready` are 0. This holds even if reset arrives in the middle of a frame.
- R2: Each byte is sent as two nibbles on consecutive clocks. Bits [3:0] go first and bits [7:4] second.
- R3: Every frame starts with 15 nibbles of 0x5 followed by one nibble of 0xD. This is seven 0x55 bytes and one 0xD5 byte.
- R4: `tx_en` is 1 from the first preamble nibble through the last check-sequence nibble without a gap, and 0 on the next clock. A body of n bytes gives 2*(8 + max(n,60) + 4) nibbles.
- R5: Body bytes go out in the order they were accepted. A byte is accepted at a rising edge where `s_valid` and `s_ready` are both 1. For a frame fed without stalls, `s_ready` is high for exactly n cycles.
- R6: When `s_last` arrives with fewer than 60 body bytes, 0x00 bytes are appended until the body is 60 bytes long. A body of 60 bytes or more gets no fill.
- R7: After the body and fill come four check bytes, least significant byte first. They hold the complement of a CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, taken over body and fill. Running the same register over body, fill and check bytes leaves 0xDEBB20E3.
- R8: If `s_ready` is 1 and `s_valid` is 0 at a rising edge during a frame, a 0x00 filler byte is sent in that byte slot. `tx_er` is 1 from the first nibble of that filler byte until the frame ends.
- R9: `tx_er` is never 1 while `tx_en` is 0.
- R10: Between the last nibble of one frame and the first nibble of the next, `tx_en` stays 0 for at least 24 clocks.
- R11: `s_ready` is 0 whenever `tx_en` is 0. It is also 0 during preamble, fill and check-sequence transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_data | input | 8 | Frame body byte from the MAC |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | `s_data` is the final body byte |
| s_ready | output | 1 | Framer takes `s_data` at this edge |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Frame in progress on `txd` |
| tx_er | output | 1 | Current frame is corrupted |

## Verification
The bench targets fill boundaries with bodies of 1, 14, 59, 60, 61 and 100 bytes. A design that compares the length off by one would either pad a 60-byte body or leave a 59-byte body short, and the nibble count and check sequence would both disagree. The check bytes are compared against an independently computed CRC and also pass the residue test. A wrong byte order or a missing final complement would fail both. A source stall mid-body must yield a zero byte on a byte boundary with a sticky error flag. Reset in mid-frame and back-to-back frames test that the enable drops at once and that the gap is never shortened.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  localparam logic [7:0] PRE_BYTE  = 8'h55;
  localparam logic [7:0] SFD_BYTE  = 8'hD5;
  localparam logic [7:0] FILL_BYTE = 8'h00;

  // One byte through a reflected CRC register, bit 0 of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc,
                                             input logic [7:0]  b,
                                             input logic [31:0] poly);
    logic [31:0] r;
    r = crc ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  // Nibble of a byte for a given half: 0 selects [3:0], 1 selects [7:4].
  function automatic logic [3:0] nibble_sel(input logic [7:0] b, input logic half);
    return half ? b[7:4] : b[3:0];
  endfunction

endpackage

// File: rtl/mii_nibble_ser.sv
module mii_nibble_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       stop,
  input  logic [7:0] byte_in,
  output logic [3:0] txd,
  output logic       active,
  output logic       byte_end
);
  import mii_tx_pkg::*;

  logic [7:0] byte_q;
  logic       half_q;
  logic       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      half_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (load) begin
      byte_q <= byte_in;
      half_q <= 1'b0;
      act_q  <= 1'b1;
    end else if (stop) begin
      half_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (act_q) begin
      half_q <= ~half_q;
    end
  end

  assign txd      = act_q ? nibble_sel(byte_q, half_q) : 4'h0;
  assign active   = act_q;
  assign byte_end = act_q & half_q;
endmodule

// File: rtl/mii_crc32_acc.sv
module mii_crc32_acc #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [31:0] fcs
);
  import mii_tx_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '1;
    else if (clr) crc_q <= '1;
    else if (upd) crc_q <= crc32_step(crc_q, data, POLY);
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/mii_ifg_timer.sv
module mii_ifg_timer #(
  parameter int IFG = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(IFG + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= CW'(IFG);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign done = (left_q == '0);
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int          PRE_BYTES  = 7,
  parameter int          MIN_BODY   = 60,
  parameter int          FCS_BYTES  = 4,
  parameter int          IFG_CYCLES = 24,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  import mii_tx_pkg::*;

  localparam int CNT_W = $clog2(PRE_BYTES + FCS_BYTES + 1);
  localparam int LEN_W = $clog2(MIN_BODY + 1);

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             last_q, last_d;
  logic             err_q;
  logic [31:0]      fcs_q, fcs_d;

  logic             ser_load, ser_stop, ser_active, byte_end;
  logic [7:0]       ser_byte;
  logic             crc_clr, crc_upd;
  logic [31:0]      crc_fcs;
  logic             gap_start, gap_done;

  // Named internal events
  logic body_phase, body_open, pad_needed, tail_step, ev_underrun;

  assign body_phase  = (st_q == ST_SFD) || (st_q == ST_BODY);
  assign body_open   = (st_q == ST_SFD) || !last_q;
  assign pad_needed  = len_q < LEN_W'(MIN_BODY);
  assign tail_step   = byte_end && ((st_q == ST_PAD) || (st_q == ST_BODY && last_q));
  assign s_ready     = byte_end && body_phase && body_open;
  assign ev_underrun = s_ready && !s_valid;

  mii_nibble_ser u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ser_load),
    .stop     (ser_stop),
    .byte_in  (ser_byte),
    .txd      (txd),
    .active   (ser_active),
    .byte_end (byte_end)
  );

  mii_crc32_acc #(.POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .upd   (crc_upd),
    .data  (ser_byte),
    .fcs   (crc_fcs)
  );

  mii_ifg_timer #(.IFG(IFG_CYCLES)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gap_start),
    .done  (gap_done)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    last_d    = last_q;
    fcs_d     = fcs_q;
    ser_load  = 1'b0;
    ser_stop  = 1'b0;
    ser_byte  = FILL_BYTE;
    crc_clr   = 1'b0;
    crc_upd   = 1'b0;
    gap_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (s_valid) begin
          ser_load = 1'b1;
          ser_byte = PRE_BYTE;
          cnt_d    = CNT_W'(1);
          len_d    = '0;
          last_d   = 1'b0;
          crc_clr  = 1'b1;
          st_d     = ST_PRE;
        end
      end
      ST_PRE: begin
        if (byte_end) begin
          ser_load = 1'b1;
          if (cnt_q < CNT_W'(PRE_BYTES)) begin
            ser_byte = PRE_BYTE;
            cnt_d    = cnt_q + 1'b1;
          end else begin
            ser_byte = SFD_BYTE;
            st_d     = ST_SFD;
          end
        end
      end
      ST_SFD, ST_BODY: begin
        if (s_ready) begin
          ser_load = 1'b1;
          crc_upd  = 1'b1;
          ser_byte = s_valid ? s_data : FILL_BYTE;
          last_d   = s_valid && s_last;
          if (pad_needed) len_d = len_q + 1'b1;
          st_d     = ST_BODY;
        end
      end
      ST_FCS: begin
        if (byte_end) begin
          if (cnt_q < CNT_W'(FCS_BYTES)) begin
            ser_load = 1'b1;
            ser_byte = fcs_q[7:0];
            fcs_d    = fcs_q >> 8;
            cnt_d    = cnt_q + 1'b1;
          end else begin
            ser_stop  = 1'b1;
            gap_start = 1'b1;
            st_d      = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_done) st_d = ST_IDLE;
      end
      default: st_d = st_q;
    endcase

    // Body finished: fill up to the minimum, then start the check sequence.
    if (tail_step) begin
      ser_load = 1'b1;
      if (pad_needed) begin
        ser_byte = FILL_BYTE;
        crc_upd  = 1'b1;
        len_d    = len_q + 1'b1;
        st_d     = ST_PAD;
      end else begin
        ser_byte = crc_fcs[7:0];
        fcs_d    = crc_fcs >> 8;
        cnt_d    = CNT_W'(1);
        st_d     = ST_FCS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
      fcs_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      last_q <= last_d;
      fcs_q  <= fcs_d;
      if (ser_stop)         err_q <= 1'b0;
      else if (ev_underrun) err_q <= 1'b1;
    end
  end

  assign tx_en = ser_active;
  assign tx_er = err_q;
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
  parameter int IFG = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] txd,
  input logic       tx_en,
  input logic       tx_er,
  input logic       s_ready,
  input logic       s_valid
);
  localparam int GW = $clog2(IFG + 2);

  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    low_cnt <= GW'(IFG);
    else if (tx_en)                low_cnt <= '0;
    else if (low_cnt < GW'(IFG))   low_cnt <= low_cnt + 1'b1;
  end

  assert_er_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er |-> tx_en);

  assert_ready_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> tx_en);

  assert_preamble_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == 4'h5));

  assert_underrun_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> tx_er);

  assert_er_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_er) |=> (tx_er || !tx_en));

  assert_gap_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (low_cnt >= GW'(IFG)));
endmodule

bind mii_tx_framer mii_tx_framer_chk #(.IFG(IFG_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .txd     (txd),
  .tx_en   (tx_en),
  .tx_er   (tx_er),
  .s_ready (s_ready),
  .s_valid (s_valid)
);

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [3:0] txd;
  logic       tx_en;
  logic       tx_er;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mii_tx_framer i_mii_tx_framer (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  // Stimulus/expectation table: body length, pattern seed, expected fill bytes
  localparam int NV = 6;
  localparam int         V_LEN  [NV] = '{60, 14, 59, 61, 100, 1};
  localparam logic [7:0] V_SEED [NV] = '{8'h12, 8'hA7, 8'h3C, 8'hF0, 8'h01, 8'h9E};
  localparam int         V_FILL [NV] = '{0, 46, 1, 0, 0, 59};

  logic [3:0] nib [0:1023];
  bit         ner [0:1023];
  int         nnib, low_run, ready_cnt;

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] byte_at(input int i);
    return {nib[2*i+1], nib[2*i]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [7:0] seed, input int stall_at, input int stall_len);
    int idx = 0;
    int stalled = 0;
    while (idx < n) begin
      @(negedge clk);
      if (idx == stall_at && stalled < stall_len) begin
        s_valid = 1'b0;
        stalled++;
      end else begin
        s_valid = 1'b1;
        s_data  = pat(seed, idx);
        s_last  = (idx == n - 1);
        if (s_ready) idx++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic capture();
    nnib = 0; low_run = 0; ready_cnt = 0;
    while (!tx_en) begin
      low_run++;
      if (s_ready) ready_cnt++;
      @(negedge clk);
    end
    while (tx_en) begin
      nib[nnib] = txd;
      ner[nnib] = tx_er;
      nnib++;
      if (s_ready) ready_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic verify(input int n, input logic [7:0] seed, input int fill);
    int body = n + fill;
    int bad = -1;
    bit pre_ok = 1;
    bit any_er = 0;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] got_fcs;
    check(nnib == 2 * (8 + body + 4), "R4", "nibble count", nnib, 2 * (8 + body + 4));
    for (int i = 0; i < 15; i++) if (nib[i] != 4'h5) pre_ok = 0;
    if (nib[15] != 4'hD) pre_ok = 0;
    check(pre_ok, "R3", "preamble/delimiter", {nib[14], nib[15]}, 8'h5D);
    check(nib[16] == seed[3:0] && nib[17] == seed[7:4], "R2", "first body nibbles",
          {nib[17], nib[16]}, seed);
    for (int i = 0; i < body; i++) begin
      logic [7:0] e = (i < n) ? pat(seed, i) : 8'h00;
      if (bad < 0 && byte_at(8 + i) != e) bad = i;
      c = ref_crc(c, e);
    end
    check(bad < 0, "R5", "body byte mismatch index", bad, -1);
    if (fill > 0) check(byte_at(8 + body - 1) == 8'h00, "R6", "last fill byte", byte_at(8 + body - 1), 0);
    got_fcs = {byte_at(8 + body + 3), byte_at(8 + body + 2), byte_at(8 + body + 1), byte_at(8 + body)};
    check(got_fcs == ~c, "R7", "check sequence", got_fcs, ~c);
    for (int i = 0; i < 4; i++) c = ref_crc(c, byte_at(8 + body + i));
    check(c == 32'hDEBB20E3, "R7", "residue", c, 32'hDEBB20E3);
    for (int i = 0; i < nnib; i++) if (ner[i]) any_er = 1;
    check(!any_er, "R8", "error flag on clean frame", any_er, 0);
    check(ready_cnt == n, "R11", "ready cycles", ready_cnt, n);
  endtask

  initial begin
    #(10 * 150000);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(!tx_en && !tx_er && !s_ready, "R1", "outputs in reset", {tx_en, tx_er, s_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_en && !tx_er && !s_ready, "R1", "outputs after reset", {tx_en, tx_er, s_ready}, 0);

    // Table walk: back-to-back frames
    for (int v = 0; v < NV; v++) begin
      fork
        send(V_LEN[v], V_SEED[v], -1, 0);
        capture();
      join
      verify(V_LEN[v], V_SEED[v], V_FILL[v]);
      if (v > 0) check(low_run >= 24, "R10", "idle gap", low_run, 24);
    end

    // Underrun in mid-body
    fork
      send(70, 8'h44, 20, 3);
      capture();
    join
    begin
      int first = -1;
      bit sticky = 1;
      bit pre_clean = 1;
      for (int i = 0; i < nnib; i++) begin
        if (first < 0 && ner[i]) first = i;
        if (first >= 0 && !ner[i]) sticky = 0;
        if (i < 16 && ner[i]) pre_clean = 0;
      end
      check(pre_clean && first >= 16, "R8", "error starts inside body", first, 16);
      check(first >= 0 && first % 2 == 0, "R8", "error starts on byte boundary", first, 0);
      check(first >= 0 && byte_at(first / 2) == 8'h00, "R8", "filler byte", byte_at(first / 2), 0);
      check(sticky, "R8", "error held to frame end", sticky, 1);
      check(!tx_er, "R9", "error low after frame", tx_er, 0);
    end

    // Reset in the middle of a frame
    s_valid = 1'b1; s_data = 8'h77; s_last = 1'b0;
    repeat (40) @(negedge clk);
    check(tx_en == 1'b1, "R4", "frame running before reset", tx_en, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!tx_en && !tx_er && !s_ready, "R1", "mid-frame reset", {tx_en, tx_er, s_ready}, 0);
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_en && !tx_er && !s_ready, "R1", "idle after mid-frame reset", {tx_en, tx_er, s_ready}, 0);

    // One clean frame after reset to show recovery
    fork
      send(14, 8'h5A, -1, 0);
      capture();
    join
    verify(14, 8'h5A, 46);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule